// File: doc/BRIEF.md
# Dithered Fixed-Rate Pulse-Width Generator

This block drives one pulse-width modulated pin at a constant period of 2^BASE_W clock cycles. The set-point it accepts is wider than the period counter. The extra low-order bits are not dropped: once per period they are added into an error accumulator. Each time that sum overflows, the next pulse is one count longer. Each pulse therefore takes one of two adjacent widths. Averaged over many periods, the high time tracks the full set-point to the resolution of its lowest bit.

The set-point is captured on a load strobe. A new value takes effect only when a period ends, so no pulse is ever cut short or stretched partway through. A one-cycle marker flags the first cycle of each period, so that logic downstream can align to the pulse train. With default parameters the set-point is 24 bits wide and the period is 1024 cycles. A smaller build, for example a 6-bit counter with 3 fractional bits, gives a shorter period and a faster pulse rate.

Top module: `dpwm_gen`

## Requirements
- R1: While reset is asserted, both outputs are low. After release, the pin stays low throughout the first period, and the accumulator starts at zero.
- R2: A period lasts exactly 2^BASE_W cycles (1024 by default). `per_start_o` is high in the first cycle of every period after the first, and low in all other cycles.
- R3: In each period the pin is high for the first W cycles and low for the rest, where W is the active width of that period. When W is 0, the pin is low for the whole period.
- R4: The active width may reach 2^BASE_W (base field all ones plus a carry). When it does, the pin stays high for the whole period.
- R5: At every period boundary, the fractional field is added into the FRAC_W-bit accumulator. The carry out of the top bit selects width base+1; no carry selects width base. Only the low FRAC_W bits of the sum are kept, so every width is either base or base+1.
- R6: Set-point bits [SP_W-1:FRAC_W] form the base width, and bits [FRAC_W-1:0] form the fraction. By default these are bits [23:14] and [13:0].
- R7: The set-point is captured on a clock edge where `sp_ld_i` is high. It is first used at the first boundary that comes after that edge. A strobe in the last cycle of a period is captured at the boundary edge itself, so it waits one more period. The active width never changes within a period.
- R8: The accumulator keeps its value when a new set-point is loaded. It changes only at period boundaries.
- R9: With 3 fractional bits, a fraction of 3, and a cleared accumulator, the extra-count pattern over eight periods is 0,0,1,0,0,1,0,1. There are never more than two unwidened periods in a row.
- R10: Over any 2^FRAC_W consecutive periods with the set-point held constant, the total number of high cycles equals the integer value of the set-point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| sp_i | input | SP_W (24) | Set-point: base width in the high bits, fraction in the low bits |
| sp_ld_i | input | 1 | Capture strobe for `sp_i` |
| pwm_o | output | 1 | Modulated output pin |
| per_start_o | output | 1 | High in the first cycle of each period |

## Verification
The properties assume that `sp_ld_i` and `sp_i` are settled before the sampling edge. They also assume that the pin is observed only while the internal reset is released, apart from the reset check, which holds during reset. The bench changes every input on the falling clock edge. It holds each strobe for exactly one cycle and places it at a chosen cycle within the period, including the final cycle that coincides with a boundary. It keeps the set-point constant for the whole window whenever an exact total is checked.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // Default split of the set-point word
  localparam int unsigned DEF_BASE_W = 10;
  localparam int unsigned DEF_FRAC_W = 14;
endpackage

// File: rtl/dpwm_rst_sync.sv
// Asynchronous assertion, synchronous release of the internal reset.
module dpwm_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/dpwm_period_ctr.sv
// Free-running period counter; wrap_o marks the last cycle of a period.
module dpwm_period_ctr #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;
endmodule

// File: rtl/dpwm_dither.sv
// Holds the captured set-point and the fractional error accumulator,
// and forms the width for the coming period.
module dpwm_dither #(
  parameter int unsigned BASE_W = 10,
  parameter int unsigned FRAC_W = 14,
  localparam int unsigned SP_W  = BASE_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic              step_i,
  output logic [BASE_W:0]   nxt_w_o,
  output logic [FRAC_W-1:0] acc_o,
  output logic [BASE_W-1:0] base_o
);
  logic [SP_W-1:0]   shd_q, shd_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;
  logic              carry;

  // capture enable for the set-point shadow
  always_comb begin
    shd_d = shd_q;
    if (ld_i) shd_d = sp_i;
  end

  // accumulate once per period; the carry is dropped from the stored sum
  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, shd_q[FRAC_W-1:0]};
    carry = sum[FRAC_W];
    acc_d = acc_q;
    if (step_i) acc_d = sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      acc_q <= '0;
    end else begin
      shd_q <= shd_d;
      acc_q <= acc_d;
    end
  end

  assign base_o  = shd_q[SP_W-1:FRAC_W];
  assign nxt_w_o = {1'b0, base_o} + {{BASE_W{1'b0}}, carry};
  assign acc_o   = acc_q;
endmodule

// File: rtl/dpwm_compare.sv
// Active width register, loaded only at a boundary, and the comparator.
module dpwm_compare #(
  parameter int unsigned BASE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BASE_W:0]   width_i,
  input  logic [BASE_W-1:0] cnt_i,
  output logic [BASE_W:0]   act_o,
  output logic              pwm_o,
  output logic              start_o
);
  logic [BASE_W:0] act_q, act_d;
  logic            st_q, st_d;

  always_comb begin
    act_d = act_q;
    if (load_i) act_d = width_i;
    st_d = load_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      st_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      st_q  <= st_d;
    end
  end

  assign act_o   = act_q;
  assign pwm_o   = ({1'b0, cnt_i} < act_q);
  assign start_o = st_q;
endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen import dpwm_pkg::*; #(
  parameter int unsigned BASE_W = DEF_BASE_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned SP_W  = BASE_W + FRAC_W
) (
  input  logic            clk_i,
  input  logic            arst_ni,
  input  logic [SP_W-1:0] sp_i,
  input  logic            sp_ld_i,
  output logic            pwm_o,
  output logic            per_start_o
);
  logic              rst_n_s;
  logic [BASE_W-1:0] cnt_w;
  logic              wrap_w;
  logic [BASE_W:0]   nxt_w;
  logic [BASE_W:0]   act_w;
  logic [FRAC_W-1:0] acc_w;
  logic [BASE_W-1:0] shd_base_w;

  dpwm_rst_sync i_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n_s)
  );

  dpwm_period_ctr #(.CNT_W(BASE_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  dpwm_dither #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) i_dith (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .ld_i    (sp_ld_i),
    .sp_i    (sp_i),
    .step_i  (wrap_w),
    .nxt_w_o (nxt_w),
    .acc_o   (acc_w),
    .base_o  (shd_base_w)
  );

  dpwm_compare #(.BASE_W(BASE_W)) i_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .load_i  (wrap_w),
    .width_i (nxt_w),
    .cnt_i   (cnt_w),
    .act_o   (act_w),
    .pwm_o   (pwm_o),
    .start_o (per_start_o)
  );
endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
  parameter int unsigned BASE_W = 10,
  parameter int unsigned FRAC_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BASE_W-1:0] cnt_i,
  input logic              wrap_i,
  input logic [BASE_W:0]   act_i,
  input logic [FRAC_W-1:0] acc_i,
  input logic [BASE_W-1:0] base_i,
  input logic              pwm_i,
  input logic              start_i
);
  localparam logic [BASE_W:0] FULL  = {1'b1, {BASE_W{1'b0}}};
  localparam logic [BASE_W:0] W_ONE = (BASE_W+1)'(1);

  // R1: outputs quiet during reset
  always @(negedge clk_i) begin
    if (rst_ni === 1'b0) begin
      a_rst_quiet_r1: assert (!pwm_i && !start_i);
    end
  end

  p_start_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_i == '0));

  p_start_follows_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> start_i);

  p_zero_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |-> !pwm_i);

  p_full_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == FULL) |-> pwm_i);

  p_adjacent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ((act_i == {1'b0, $past(base_i)}) ||
                (act_i == ({1'b0, $past(base_i)} + W_ONE))));

  p_width_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_i));

  p_acc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(acc_i));
endmodule

bind dpwm_gen dpwm_chk #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) i_dpwm_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_n_s),
  .cnt_i   (cnt_w),
  .wrap_i  (wrap_w),
  .act_i   (act_w),
  .acc_i   (acc_w),
  .base_i  (shd_base_w),
  .pwm_i   (pwm_o),
  .start_i (per_start_o)
);

// File: tb/test_dpwm_gen.sv
module test_dpwm_gen;
  localparam int P  = 1024;
  localparam int PS = 64;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [23:0] sp;
  logic        ld;
  logic        pwm, strt;
  logic [8:0]  sp_s;
  logic        ld_s;
  logic        pwm_s, strt_s;

  int n_chk = 0;
  int n_bad = 0;

  int unsigned m_acc = 0;
  logic [23:0] m_sp  = '0;
  int          exp_cur = 0;

  always #4 clk = ~clk;

  dpwm_gen i_dpwm_gen (
    .clk_i(clk), .arst_ni(arst_n), .sp_i(sp), .sp_ld_i(ld),
    .pwm_o(pwm), .per_start_o(strt)
  );

  dpwm_gen #(.BASE_W(6), .FRAC_W(3)) i_dpwm_small (
    .clk_i(clk), .arst_ni(arst_n), .sp_i(sp_s), .sp_ld_i(ld_s),
    .pwm_o(pwm_s), .per_start_o(strt_s)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference: width of the next period, advancing the model accumulator
  function automatic int adv();
    int unsigned s;
    s = m_acc + int'(m_sp[13:0]);
    m_acc = s & 32'h3FFF;
    return int'(m_sp[23:14]) + int'(s >> 14);
  endfunction

  // one main period, starting at the negedge of its first cycle
  task automatic per(input bit do_ld, input logic [23:0] nsp, input int at,
                     input string req, output int hi);
    int bad_cyc = 0;
    int extra = 0;
    hi = 0;
    for (int i = 0; i < P; i++) begin
      if (do_ld && i == at) begin sp = nsp; ld = 1'b1; end
      else ld = 1'b0;
      if (pwm === 1'b1) hi++;
      if (pwm !== (i < exp_cur)) bad_cyc++;
      if (i > 0 && strt !== 1'b0) extra++;
      @(negedge clk);
    end
    ld = 1'b0;
    chk(bad_cyc == 0, req, "pulse shape/high count", hi, exp_cur);
    chk(strt === 1'b1 && extra == 0, "R2", "period start spacing", extra, 0);
    if (do_ld && at < P-1) m_sp = nsp;
    exp_cur = adv();
    if (do_ld && at == P-1) m_sp = nsp;
  endtask

  task automatic t_reset();
    int bad = 0;
    arst_n = 1'b0; ld = 1'b0; sp = '0; ld_s = 1'b0; sp_s = '0;
    repeat (6) begin
      @(negedge clk);
      if (pwm !== 1'b0 || strt !== 1'b0 || pwm_s !== 1'b0 || strt_s !== 1'b0) bad++;
    end
    chk(bad == 0, "R1", "outputs during reset", bad, 0);
    arst_n = 1'b1;
  endtask

  task automatic t_small();
    int hi, tot = 0, run = 0, maxrun = 0;
    int pat[8] = '{0, 0, 1, 0, 0, 1, 0, 1};
    repeat (2) @(negedge clk);
    sp_s = 9'((20 << 3) | 3); ld_s = 1'b1;
    @(negedge clk);
    ld_s = 1'b0;
    while (strt_s !== 1'b1) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      hi = 0;
      for (int i = 0; i < PS; i++) begin
        if (pwm_s === 1'b1) hi++;
        @(negedge clk);
      end
      chk(hi == 20 + pat[k], "R9", "dither pattern width", hi, 20 + pat[k]);
      tot += hi;
      if (hi == 20) run++; else run = 0;
      if (run > maxrun) maxrun = run;
    end
    chk(tot == 163, "R10", "total high over 8 periods", tot, 163);
    chk(maxrun <= 2, "R9", "longest unwidened run", maxrun, 2);
  endtask

  task automatic t_first_period();
    int hi = 0;
    while (strt !== 1'b1) begin
      if (pwm === 1'b1) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R1", "pin low in first period", hi, 0);
    exp_cur = adv();
  endtask

  task automatic t_base();
    int hi;
    per(1'b1, 24'(300 << 14), 5, "R3", hi);
    per(1'b0, '0, 0, "R6", hi);
    chk(hi == 300, "R6", "base-only width", hi, 300);
    per(1'b0, '0, 0, "R3", hi);
  endtask

  task automatic t_half();
    int hi;
    per(1'b1, 24'((500 << 14) | 14'h2000), 5, "R5", hi);
    for (int k = 0; k < 4; k++) begin
      per(1'b0, '0, 0, "R5", hi);
      chk(hi == 500 || hi == 501, "R5", "width adjacent to base", hi, 500);
    end
  endtask

  task automatic t_full();
    int hi;
    per(1'b1, 24'((1023 << 14) | 14'h3FFF), 5, "R4", hi);
    for (int k = 0; k < 3; k++) per(1'b0, '0, 0, "R4", hi);
    chk(hi == P, "R4", "full-period high", hi, P);
  endtask

  task automatic t_zero();
    int hi;
    per(1'b1, 24'h0, 5, "R3", hi);
    per(1'b0, '0, 0, "R3", hi);
    chk(hi == 0, "R3", "zero width", hi, 0);
  endtask

  task automatic t_late_load();
    int hi;
    per(1'b1, 24'(700 << 14), P-1, "R7", hi);
    per(1'b0, '0, 0, "R7", hi);
    chk(hi == 0, "R7", "strobe at boundary deferred", hi, 0);
    per(1'b0, '0, 0, "R7", hi);
    chk(hi == 700, "R7", "deferred value applied", hi, 700);
  endtask

  task automatic t_retain();
    int hi;
    per(1'b1, 24'((100 << 14) | 14'h2000), 5, "R8", hi);
    per(1'b0, '0, 0, "R8", hi);
    per(1'b1, 24'((200 << 14) | 14'h2000), 5, "R8", hi);
    for (int k = 0; k < 2; k++) per(1'b0, '0, 0, "R8", hi);
  endtask

  initial begin
    t_reset();
    t_small();
    t_first_period();
    t_base();
    t_half();
    t_full();
    t_zero();
    t_late_load();
    t_retain();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule